// File: doc/BRIEF.md
# UART Line Status Flag Logic

This block produces the upper three bits of a UART line status word. Those bits are the transmit-empty flag, the transmitter-idle flag and the receive error summary. It works in two modes. In single-buffer mode, one holding register feeds the shift register. In FIFO mode, a transmit queue and a receive queue stand in front of the line. The FIFOs, the receive character checker and the register decode all sit outside this block. They report their events to it as single-cycle strobes and level signals.

On the transmit side, the block follows loads and transfers to keep the transmit-empty flag, and it flags every rising edge of that flag to the interrupt logic. On the receive side, it counts the receive FIFO entries that carry an error flag. The counter rises when such an entry is pushed and falls when such an entry is popped. The error summary is set while the count is nonzero. After it is set, it holds until a status read finds no errored entries left.

No data flows through this block, so there is no valid/ready interface and no back-pressure. Every input is a plain strobe or level, sampled on the rising clock edge. Every register output changes one cycle after the edge that caused it.

Top module: `uart_lsr_flags`

## Requirements
- R1: In single-buffer mode, a `tx_xfer` strobe without `tx_wr` sets `thre` to 1 in the cycle after the strobe.
- R2: In either mode, a `tx_wr` strobe clears `thre` in the cycle after the strobe. A write wins over a transfer in the same cycle.
- R3: In FIFO mode, `thre` takes the value of `tx_fifo_empty` one cycle later, whenever there is no `tx_wr` strobe.
- R4: `temt` is 1 exactly when `thre` is 1 and `tsr_busy` is 0.
- R5: In single-buffer mode, `rx_err_sum` is 0 from the cycle after the mode has been stable for one edge.
- R6: Each receive flag vector is {break, framing, parity}, in bits 2, 1 and 0. In FIFO mode, a push whose flag vector has any bit set makes `rx_err_sum` 1 in the next cycle.
- R7: In FIFO mode, `rx_err_sum` stays 1 across `lsr_rd` while errored entries remain. It also stays 1 after the last errored entry is popped, until an `lsr_rd` strobe clears it in the next cycle.
- R8: `thre_rise` is a one-cycle pulse that is high in the first cycle `thre` reads 1 after reading 0.
- R9: A change of `fifo_mode` sets `thre` to 1, clears the error count and clears `rx_err_sum`, in the cycle after the change.
- R10: An `rx_flush` strobe clears the error count and `rx_err_sum` in the next cycle. A push in the same cycle is dropped.
- R11: An `lsr_wr` test write in single-buffer mode loads `thre` from `lsr_wdata` bit 5. In FIFO mode, a test write changes no output. No test write ever sets `rx_err_sum`.
- R12: After reset, `thre`=1, `temt`=1 while `tsr_busy`=0, `rx_err_sum`=0 and `thre_rise`=0.
- R13: The error count saturates at RX_DEPTH. After more than RX_DEPTH flagged pushes, RX_DEPTH flagged pops bring it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single-buffer mode |
| tx_wr | input | 1 | CPU loads the holding register or pushes the transmit FIFO |
| tx_xfer | input | 1 | A character moves into the shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no bytes |
| tsr_busy | input | 1 | Shift register holds a character |
| rx_push | input | 1 | A byte enters the receive FIFO |
| rx_push_flags | input | 3 | {break, framing, parity} flags of the pushed byte |
| rx_pop | input | 1 | A byte leaves the receive FIFO |
| rx_pop_flags | input | 3 | {break, framing, parity} flags of the popped byte |
| rx_flush | input | 1 | The receive FIFO is being cleared |
| lsr_rd | input | 1 | The line status word is read |
| lsr_wr | input | 1 | Test write to the line status word |
| lsr_wdata | input | 8 | Test write data |
| thre | output | 1 | Transmit holding register or FIFO is empty |
| temt | output | 1 | Holding side and shift register are both empty |
| rx_err_sum | output | 1 | Receive FIFO error summary |
| thre_rise | output | 1 | Fresh transmit-empty event for the interrupt logic |

## Verification
The bench builds the block with RX_DEPTH=4. With that depth, five flagged pushes overfill the counter, so the saturation limit and the recovery after exactly four flagged pops are both reached in a short run. The small count width also puts the boundary between the errored and clean states only a few strobes apart. That lets the sticky-until-read behaviour be driven through every order of pop and read.

// File: rtl/lsr_flags_pkg.sv
package lsr_flags_pkg;

  localparam int LSR_THRE_BIT = 5;
  localparam int LSR_WIDTH    = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  function automatic logic flags_bad(input rx_flags_t f);
    return f.brk | f.frm | f.par;
  endfunction

endpackage

// File: rtl/lsr_mode_watch.sv
module lsr_mode_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  output logic mode_chg
);
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign mode_chg = fifo_mode ^ mode_q;
endmodule

// File: rtl/lsr_thre_track.sv
module lsr_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic mode_chg,
  input  logic tx_wr,
  input  logic tx_xfer,
  input  logic tx_fifo_empty,
  input  logic test_wr,
  input  logic test_thre,
  output logic thre_q,
  output logic rise_q
);
  logic thre_d;

  always_comb begin
    thre_d = thre_q;
    if (mode_chg)        thre_d = 1'b1;
    else if (tx_wr)      thre_d = 1'b0;
    else if (fifo_mode)  thre_d = tx_fifo_empty;
    else if (tx_xfer)    thre_d = 1'b1;
    else if (test_wr)    thre_d = test_thre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      thre_q <= thre_d;
      rise_q <= thre_d & ~thre_q;
    end
  end
endmodule

// File: rtl/lsr_err_count.sv
module lsr_err_count #(
  parameter int RX_DEPTH = 16,
  localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             nz_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RX_DEPTH);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign nz_next = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lsr_err_summary.sv
module lsr_err_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic clr,
  input  logic nz_next,
  input  logic lsr_rd,
  output logic err_q
);
  logic err_d;

  always_comb begin
    if (!fifo_mode || clr) err_d = 1'b0;
    else                   err_d = nz_next | (err_q & ~lsr_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags #(
  parameter int RX_DEPTH = 16,
  localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       tx_wr,
  input  logic       tx_xfer,
  input  logic       tx_fifo_empty,
  input  logic       tsr_busy,
  input  logic       rx_push,
  input  logic [2:0] rx_push_flags,
  input  logic       rx_pop,
  input  logic [2:0] rx_pop_flags,
  input  logic       rx_flush,
  input  logic       lsr_rd,
  input  logic       lsr_wr,
  input  logic [7:0] lsr_wdata,
  output logic       thre,
  output logic       temt,
  output logic       rx_err_sum,
  output logic       thre_rise
);
  import lsr_flags_pkg::*;

  logic             mode_chg;
  logic             cnt_clr;
  logic             push_bad;
  logic             pop_bad;
  logic [CNT_W-1:0] err_cnt;
  logic             cnt_nz_next;

  lsr_mode_watch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_mode),
    .mode_chg (mode_chg)
  );

  lsr_thre_track u_thre (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .mode_chg     (mode_chg),
    .tx_wr        (tx_wr),
    .tx_xfer      (tx_xfer),
    .tx_fifo_empty(tx_fifo_empty),
    .test_wr      (lsr_wr),
    .test_thre    (lsr_wdata[LSR_THRE_BIT]),
    .thre_q       (thre),
    .rise_q       (thre_rise)
  );

  assign temt     = thre & ~tsr_busy;
  assign push_bad = rx_push & flags_bad(rx_flags_t'(rx_push_flags));
  assign pop_bad  = rx_pop  & flags_bad(rx_flags_t'(rx_pop_flags));
  assign cnt_clr  = mode_chg | rx_flush | ~fifo_mode;

  lsr_err_count #(.RX_DEPTH(RX_DEPTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (push_bad),
    .dec    (pop_bad),
    .cnt_q  (err_cnt),
    .nz_next(cnt_nz_next)
  );

  lsr_err_summary u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_mode),
    .clr      (mode_chg | rx_flush),
    .nz_next  (cnt_nz_next),
    .lsr_rd   (lsr_rd),
    .err_q    (rx_err_sum)
  );
endmodule

// File: rtl/uart_lsr_flags_chk.sv
module uart_lsr_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       mode_chg,
  input logic       tx_wr,
  input logic       tx_xfer,
  input logic       rx_push,
  input logic [2:0] rx_push_flags,
  input logic       rx_pop,
  input logic       rx_flush,
  input logic       lsr_rd,
  input logic       thre,
  input logic       rx_err_sum,
  input logic       thre_rise
);
  AST_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !mode_chg) |=> !thre);  // R2

  AST_XFER_SETS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && tx_xfer && !tx_wr && !mode_chg) |=> thre);  // R1

  AST_NO_SUM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !mode_chg) |-> !rx_err_sum);  // R5

  AST_FLAGGED_PUSH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !mode_chg && !rx_flush && rx_push && !rx_pop && (rx_push_flags != 3'b000))
      |=> rx_err_sum);  // R6

  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !mode_chg && !rx_flush && rx_err_sum && !lsr_rd) |=> rx_err_sum);  // R7

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    thre_rise |-> (thre && !$past(thre)));  // R8

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_err_sum);  // R10
endmodule

bind uart_lsr_flags uart_lsr_flags_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_mode    (fifo_mode),
  .mode_chg     (mode_chg),
  .tx_wr        (tx_wr),
  .tx_xfer      (tx_xfer),
  .rx_push      (rx_push),
  .rx_push_flags(rx_push_flags),
  .rx_pop       (rx_pop),
  .rx_flush     (rx_flush),
  .lsr_rd       (lsr_rd),
  .thre         (thre),
  .rx_err_sum   (rx_err_sum),
  .thre_rise    (thre_rise)
);

// File: tb/uart_lsr_flags_bench.sv
module uart_lsr_flags_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, tx_wr = 1'b0, tx_xfer = 1'b0, tx_fifo_empty = 1'b1, tsr_busy = 1'b0;
  logic rx_push = 1'b0, rx_pop = 1'b0, rx_flush = 1'b0, lsr_rd = 1'b0, lsr_wr = 1'b0;
  logic [2:0] rx_push_flags = 3'b000, rx_pop_flags = 3'b000;
  logic [7:0] lsr_wdata = 8'h00;
  logic thre, temt, rx_err_sum, thre_rise;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_lsr_flags #(.RX_DEPTH(DEPTH)) u_uart_lsr_flags (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .tx_wr(tx_wr), .tx_xfer(tx_xfer),
    .tx_fifo_empty(tx_fifo_empty), .tsr_busy(tsr_busy), .rx_push(rx_push),
    .rx_push_flags(rx_push_flags), .rx_pop(rx_pop), .rx_pop_flags(rx_pop_flags),
    .rx_flush(rx_flush), .lsr_rd(lsr_rd), .lsr_wr(lsr_wr), .lsr_wdata(lsr_wdata),
    .thre(thre), .temt(temt), .rx_err_sum(rx_err_sum), .thre_rise(thre_rise)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One strobe cycle: caller sets strobes after a negedge; this clears them one cycle later.
  task automatic step();
    @(negedge clk);
    tx_wr = 0; tx_xfer = 0; rx_push = 0; rx_pop = 0; rx_flush = 0; lsr_rd = 0; lsr_wr = 0;
    rx_push_flags = 3'b000; rx_pop_flags = 3'b000;
  endtask

  task automatic push(input logic [2:0] f);
    rx_push = 1; rx_push_flags = f; step();
  endtask

  task automatic pop(input logic [2:0] f);
    rx_pop = 1; rx_pop_flags = f; step();
  endtask

  task automatic rd();
    lsr_rd = 1; step();
  endtask

  task automatic t_reset();
    check("R12 thre", thre, 1'b1);
    check("R12 temt", temt, 1'b1);
    check("R12 err", rx_err_sum, 1'b0);
    check("R12 rise", thre_rise, 1'b0);
  endtask

  task automatic t_single_thre();
    tx_wr = 1; step();
    check("R2 thre after load", thre, 1'b0);
    check("R4 temt after load", temt, 1'b0);
    tsr_busy = 1; tx_xfer = 1; step();
    check("R1 thre after xfer", thre, 1'b1);
    check("R8 rise pulse", thre_rise, 1'b1);
    check("R4 temt busy", temt, 1'b0);
    step();
    check("R8 rise one cycle", thre_rise, 1'b0);
    tsr_busy = 0; #1;
    check("R4 temt idle", temt, 1'b1);
    tx_wr = 1; tx_xfer = 1; step();
    check("R2 write beats xfer", thre, 1'b0);
  endtask

  task automatic t_single_test_write();
    lsr_wr = 1; lsr_wdata = 8'h20; step();
    check("R11 test write sets thre", thre, 1'b1);
    check("R8 rise on test write", thre_rise, 1'b1);
    lsr_wr = 1; lsr_wdata = 8'hDF; step();
    check("R11 test write clears thre", thre, 1'b0);
    check("R5 bit7 written ignored", rx_err_sum, 1'b0);
  endtask

  task automatic t_to_fifo();
    fifo_mode = 1; tx_fifo_empty = 1; step();
    check("R9 thre on mode change", thre, 1'b1);
    check("R9 err on mode change", rx_err_sum, 1'b0);
  endtask

  task automatic t_fifo_thre();
    tx_wr = 1; step();
    check("R2 fifo write clears", thre, 1'b0);
    tx_fifo_empty = 0; step(); step();
    check("R3 fifo not empty", thre, 1'b0);
    tx_fifo_empty = 1; step();
    check("R3 fifo empty sets", thre, 1'b1);
    check("R8 rise fifo", thre_rise, 1'b1);
  endtask

  task automatic t_fifo_errors();
    push(3'b001);
    check("R6 parity push", rx_err_sum, 1'b1);
    push(3'b000);
    rd();
    check("R7 read with errored entry", rx_err_sum, 1'b1);
    pop(3'b001);
    check("R7 sticky after last pop", rx_err_sum, 1'b1);
    pop(3'b000);
    rd();
    check("R7 read clears", rx_err_sum, 1'b0);
    push(3'b010);
    push(3'b100);
    check("R6 framing/break push", rx_err_sum, 1'b1);
    pop(3'b010);
    rd();
    check("R7 one errored left", rx_err_sum, 1'b1);
    pop(3'b100);
    rd();
    check("R7 read after all popped", rx_err_sum, 1'b0);
  endtask

  task automatic t_fifo_test_write();
    logic thre_before;
    push(3'b001);
    thre_before = thre;
    lsr_wr = 1; lsr_wdata = 8'h00; step();
    check("R11 fifo write keeps err", rx_err_sum, 1'b1);
    check("R11 fifo write keeps thre", thre, thre_before);
    pop(3'b001);
    rd();
    lsr_wr = 1; lsr_wdata = 8'hFF; step();
    check("R11 fifo write cannot set err", rx_err_sum, 1'b0);
  endtask

  task automatic t_flush();
    push(3'b100);
    push(3'b001);
    rx_flush = 1; rx_push = 1; rx_push_flags = 3'b010; step();
    check("R10 flush clears", rx_err_sum, 1'b0);
    pop(3'b100);
    check("R10 count was cleared", rx_err_sum, 1'b0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < DEPTH + 1; i++) push(3'b001);
    check("R13 full", rx_err_sum, 1'b1);
    for (int i = 0; i < DEPTH - 1; i++) pop(3'b001);
    rd();
    check("R13 one left", rx_err_sum, 1'b1);
    pop(3'b001);
    rd();
    check("R13 saturated count drains", rx_err_sum, 1'b0);
  endtask

  task automatic t_to_single();
    push(3'b010);
    check("R6 before leaving fifo", rx_err_sum, 1'b1);
    tx_wr = 1; step();
    fifo_mode = 0; step();
    check("R9 leave fifo thre", thre, 1'b1);
    check("R9 leave fifo err", rx_err_sum, 1'b0);
    step();
    check("R5 single mode bit7", rx_err_sum, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_thre();
    t_single_test_write();
    t_to_fifo();
    t_fifo_thre();
    t_fifo_errors();
    t_fifo_test_write();
    t_flush();
    t_saturate();
    t_to_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule